// File: doc/BRIEF.md
# Match-Compare Operating-System Tick Timer

This block is a one-shot tick timer for an operating-system scheduler. Software writes a target value into the match register, which arms a run. The free counter then climbs by one on each tick-enable pulse, starting from whatever value it holds, until it equals the target. At that point the counter freezes on the target and the run ends. If interrupts are enabled, a status flag is set and a level interrupt is raised. Software drops the interrupt by writing zero to the status register. Each new match write re-arms the timer. When the target is at or below the counter, the count passes through the all-ones value and zero before it lands.

Software reaches the block over a simple single-cycle word bus: one access per cycle, with strobe, write flag, byte address and 32-bit write data. Read data and an error pulse come back one cycle later. The tick enable lets a fast system clock run the counter at a slower fixed rate, nominally 50 MHz.

Run control is a three-state machine. IDLE is the state after reset. It moves to RUN on a match write (the *arm* transition). RUN moves to HELD when an increment lands on the target (*land*). RUN also stays in RUN on a fresh match write (*retarget*). HELD moves back to RUN on a match write (*re-arm*). No state is left for any other reason.

Top module: `ostick_timer`

## Requirements
- R1: After reset the counter, target, status and enable all read zero and `irq_o` is low. The timer is in IDLE, so tick pulses leave the counter at zero.
- R2: The byte offsets are fixed. 0x00 is the target (write only). 0x10 is the counter (read only, zero-extended). 0x14 is status (read returns the flag in bit 0; write zero clears it). 0x1C is the 32-bit enable (read/write). Read data appears on `bus_rdata_o` one cycle after the access and is zero in every other cycle.
- R3: Any of the following raises `bus_err_o` for exactly the next cycle, returns zero read data and changes no state: a read of 0x00, a write of 0x10, an access to any other offset, or a nonzero write to 0x14.
- R4: A write to 0x00 loads the low CNT_W bits as the target and starts a run from the current counter value. During a run the counter rises by one only in cycles where `tick_en_i` is high.
- R5: When an increment makes the counter equal the target, the counter stops there. It holds that value through further ticks until 0x00 is written again.
- R6: When the target is not above the counter, the run passes through the all-ones value and zero. A target equal to the counter takes 2^CNT_W ticks.
- R7: On a landing with a nonzero enable, status becomes 1 and `irq_o` rises on the same clock edge that puts the target into the counter.
- R8: On a landing with enable zero, neither status nor `irq_o` is set. Enable written in the landing cycle takes effect only afterwards.
- R9: Writing zero to 0x14 while status is set clears status and lowers `irq_o` on that edge. When status is already clear, the write has no effect.
- R10: A landing takes priority over a status clear in the same cycle, so status stays set. A target write in the landing cycle cancels the landing: no flag is raised, and the run continues toward the new target from the incremented counter.
- R11: A target write during a run retargets it without resetting the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | One-cycle pulse that advances a running counter |
| bus_valid_i | input | 1 | Access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid one cycle after a legal read |
| bus_err_o | output | 1 | One-cycle pulse after an illegal access |
| irq_o | output | 1 | Level interrupt, high while status is set |

## Verification
The bench tries the counting function with short targets just above the counter, which separates correct landing from off-by-one stops. It also uses targets below and equal to the counter, which separates true wrap-through from an early stop or a stall. Runs with enable both zero and nonzero separate the flagging path from the landing itself. Ticks held low, ticks pulsed at random, and accesses timed onto the exact landing cycle expose ordering mistakes between arming, clearing and landing. The bench mixes all of these with random bus traffic, including bad offsets, and compares every cycle against a reference model built from the requirements.

// File: rtl/ostick_pkg.sv
package ostick_pkg;

    // Run-control states of the one-shot timer.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HELD = 2'd2
    } run_state_e;

    // Decoded register selection.
    typedef enum logic [2:0] {
        SEL_NONE   = 3'd0,
        SEL_MATCH  = 3'd1,
        SEL_COUNT  = 3'd2,
        SEL_STATUS = 3'd3,
        SEL_ENABLE = 3'd4
    } reg_sel_e;

    // Byte offsets of the register file.
    localparam int unsigned OFS_MATCH  = 32'h00;
    localparam int unsigned OFS_COUNT  = 32'h10;
    localparam int unsigned OFS_STATUS = 32'h14;
    localparam int unsigned OFS_ENABLE = 32'h1C;

endpackage

// File: rtl/ostick_busif.sv
module ostick_busif
    import ostick_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              valid_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              status_i,
    input  logic [DATA_W-1:0] enable_i,
    output logic              arm_o,
    output logic [CNT_W-1:0]  arm_val_o,
    output logic              clr_o,
    output logic              en_wr_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              err_o
);

    reg_sel_e          sel;
    logic              zero_wdata;
    logic              wr_ok;
    logic              rd_ok;
    logic              legal;
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] rdata_d;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;

    // Offset decode.
    always_comb begin
        case (addr_i)
            ADDR_W'(OFS_MATCH):  sel = SEL_MATCH;
            ADDR_W'(OFS_COUNT):  sel = SEL_COUNT;
            ADDR_W'(OFS_STATUS): sel = SEL_STATUS;
            ADDR_W'(OFS_ENABLE): sel = SEL_ENABLE;
            default:             sel = SEL_NONE;
        endcase
    end

    assign zero_wdata = (wdata_i == '0);

    // Per-register legality and read mux.
    always_comb begin
        wr_ok  = 1'b0;
        rd_ok  = 1'b0;
        rd_val = '0;
        unique case (sel)
            SEL_MATCH: begin
                wr_ok = 1'b1;
            end
            SEL_COUNT: begin
                rd_ok  = 1'b1;
                rd_val = DATA_W'(cnt_i);
            end
            SEL_STATUS: begin
                wr_ok  = zero_wdata;
                rd_ok  = 1'b1;
                rd_val = DATA_W'(status_i);
            end
            SEL_ENABLE: begin
                wr_ok  = 1'b1;
                rd_ok  = 1'b1;
                rd_val = enable_i;
            end
            default: begin
                wr_ok = 1'b0;
            end
        endcase
    end

    assign legal     = valid_i && (wr_i ? wr_ok : rd_ok);
    assign arm_o     = valid_i && wr_i && (sel == SEL_MATCH);
    assign clr_o     = valid_i && wr_i && (sel == SEL_STATUS) && zero_wdata;
    assign en_wr_o   = valid_i && wr_i && (sel == SEL_ENABLE);
    assign arm_val_o = wdata_i[CNT_W-1:0];
    assign rdata_d   = (legal && !wr_i) ? rd_val : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            rdata_q <= rdata_d;
            err_q   <= valid_i && !legal;
        end
    end

    assign rdata_o = rdata_q;
    assign err_o   = err_q;

endmodule

// File: rtl/ostick_runctl.sv
module ostick_runctl
    import ostick_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             arm_i,
    input  logic [CNT_W-1:0] arm_val_i,
    output run_state_e       state_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] match_o,
    output logic             hit_o
);

    run_state_e       state_q;
    run_state_e       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] match_q;
    logic [CNT_W-1:0] match_d;
    logic             step;
    logic             landed;

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arm_i) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (arm_i)       state_d = ST_RUN;
                else if (landed) state_d = ST_HELD;
            end
            ST_HELD: begin
                if (arm_i) state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Datapath outputs: increment, landing compare, target load.
    always_comb begin
        cnt_inc = cnt_q + CNT_W'(1);
        step    = (state_q == ST_RUN) && tick_i;
        landed  = step && (cnt_inc == match_q);
        cnt_d   = step ? cnt_inc : cnt_q;
        match_d = arm_i ? arm_val_i : match_q;
        hit_o   = landed && !arm_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q   <= '0;
            match_q <= '0;
        end else begin
            cnt_q   <= cnt_d;
            match_q <= match_d;
        end
    end

    assign state_o = state_q;
    assign cnt_o   = cnt_q;
    assign match_o = match_q;

endmodule

// File: rtl/ostick_flag.sv
module ostick_flag #(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              hit_i,
    input  logic              clr_i,
    input  logic              en_wr_i,
    input  logic [DATA_W-1:0] en_val_i,
    output logic              status_o,
    output logic [DATA_W-1:0] enable_o,
    output logic              irq_o
);

    logic [DATA_W-1:0] en_q;
    logic              status_q;
    logic              status_d;
    logic              irq_q;

    // Landing outranks a clear; enable is sampled before its own update.
    always_comb begin
        status_d = status_q;
        if (hit_i && (en_q != '0)) begin
            status_d = 1'b1;
        end else if (clr_i) begin
            status_d = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_q     <= '0;
            status_q <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            status_q <= status_d;
            irq_q    <= status_d;
            if (en_wr_i) en_q <= en_val_i;
        end
    end

    assign status_o = status_q;
    assign enable_o = en_q;
    assign irq_o    = irq_q;

endmodule

// File: rtl/ostick_timer.sv
module ostick_timer
    import ostick_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_en_i,
    input  logic              bus_valid_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              bus_err_o,
    output logic              irq_o
);

    run_state_e        state_w;
    logic [CNT_W-1:0]  cnt_w;
    logic [CNT_W-1:0]  match_w;
    logic [CNT_W-1:0]  arm_val_w;
    logic              hit_w;
    logic              arm_w;
    logic              clr_w;
    logic              en_wr_w;
    logic              status_w;
    logic [DATA_W-1:0] en_w;

    ostick_busif #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) u_busif (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .valid_i  (bus_valid_i),
        .wr_i     (bus_wr_i),
        .addr_i   (bus_addr_i),
        .wdata_i  (bus_wdata_i),
        .cnt_i    (cnt_w),
        .status_i (status_w),
        .enable_i (en_w),
        .arm_o    (arm_w),
        .arm_val_o(arm_val_w),
        .clr_o    (clr_w),
        .en_wr_o  (en_wr_w),
        .rdata_o  (bus_rdata_o),
        .err_o    (bus_err_o)
    );

    ostick_runctl #(
        .CNT_W(CNT_W)
    ) u_runctl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_en_i),
        .arm_i    (arm_w),
        .arm_val_i(arm_val_w),
        .state_o  (state_w),
        .cnt_o    (cnt_w),
        .match_o  (match_w),
        .hit_o    (hit_w)
    );

    ostick_flag #(
        .DATA_W(DATA_W)
    ) u_flag (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .hit_i   (hit_w),
        .clr_i   (clr_w),
        .en_wr_i (en_wr_w),
        .en_val_i(bus_wdata_i),
        .status_o(status_w),
        .enable_o(en_w),
        .irq_o   (irq_o)
    );

endmodule

// File: rtl/ostick_timer_chk.sv
module ostick_timer_chk
    import ostick_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tick_en_i,
    input logic              bus_valid_i,
    input logic              bus_err_o,
    input logic              irq_o,
    input run_state_e        state_w,
    input logic [CNT_W-1:0]  cnt_w,
    input logic [CNT_W-1:0]  match_w,
    input logic              hit_w,
    input logic              arm_w,
    input logic              clr_w,
    input logic [DATA_W-1:0] en_w
);

    p_idle_counter_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_w == ST_IDLE) |-> (cnt_w == '0));

    p_err_follows_access_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_err_o |-> $past(bus_valid_i));

    p_no_tick_no_move_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_en_i |=> $stable(cnt_w));

    p_lands_on_target_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_w |=> (cnt_w == $past(match_w)));

    p_held_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state_w == ST_HELD) && !arm_w) |=> $stable(cnt_w));

    p_irq_rise_needs_enable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> ($past(hit_w) && ($past(en_w) != '0)));

    p_irq_fall_on_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(irq_o) |-> $past(clr_w));

endmodule

bind ostick_timer ostick_timer_chk #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_en_i  (tick_en_i),
    .bus_valid_i(bus_valid_i),
    .bus_err_o  (bus_err_o),
    .irq_o      (irq_o),
    .state_w    (state_w),
    .cnt_w      (cnt_w),
    .match_w    (match_w),
    .hit_w      (hit_w),
    .arm_w      (arm_w),
    .clr_w      (clr_w),
    .en_w       (en_w)
);

// File: tb/ostick_timer_tb_top.sv
`timescale 1ns/100ps
module ostick_timer_tb_top;

    localparam int CW   = 10;
    localparam int MASK = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bv = 1'b0;
    logic        bw = 1'b0;
    logic [4:0]  ba = '0;
    logic [31:0] bd = '0;
    logic [31:0] rdata;
    logic        err;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model state.
    int unsigned m_cnt = 0, m_match = 0, m_en = 0, m_rdata = 0;
    bit m_run = 0, m_status = 0, m_irq = 0, m_err = 0;

    always #2.5 clk = ~clk;

    ostick_timer #(.ADDR_W(5), .DATA_W(32), .CNT_W(CW)) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .tick_en_i  (tick),
        .bus_valid_i(bv),
        .bus_wr_i   (bw),
        .bus_addr_i (ba),
        .bus_wdata_i(bd),
        .bus_rdata_o(rdata),
        .bus_err_o  (err),
        .irq_o      (irq)
    );

    // One clock edge of the reference model, from the requirements.
    task automatic model_edge(input bit v, input bit w, input logic [4:0] a,
                              input logic [31:0] d, input bit t);
        bit legal, arm, clr, enw, stepc, landed, hit;
        int unsigned rv, inc;
        legal = 0; rv = 0;
        if (v) begin
            if (w) legal = (a == 5'h00) || (a == 5'h1C) || (a == 5'h14 && d == 0);
            else begin
                case (a)
                    5'h10: begin legal = 1; rv = m_cnt; end
                    5'h14: begin legal = 1; rv = {31'b0, m_status}; end
                    5'h1C: begin legal = 1; rv = m_en; end
                    default: legal = 0;
                endcase
            end
        end
        arm   = v && w && a == 5'h00;
        clr   = v && w && a == 5'h14 && d == 0;
        enw   = v && w && a == 5'h1C;
        inc   = (m_cnt + 1) & MASK;
        stepc = m_run && t;
        landed = stepc && (inc == m_match);
        hit   = landed && !arm;
        m_rdata = (legal && !w) ? rv : 0;
        m_err   = v && !legal;
        if (stepc) m_cnt = inc;
        if (arm) begin m_match = d & MASK; m_run = 1; end
        else if (landed) m_run = 0;
        if (hit && m_en != 0) m_status = 1;
        else if (clr) m_status = 0;
        m_irq = m_status;
        if (enw) m_en = d;
    endtask

    task automatic step(input bit v, input bit w, input logic [4:0] a,
                        input logic [31:0] d, input bit t, input string tag);
        bv = v; bw = w; ba = a; bd = d; tick = t;
        @(posedge clk);
        model_edge(v, w, a, d, t);
        @(negedge clk);
        checks++;
        if (irq !== m_irq || err !== m_err || rdata !== m_rdata) begin
            fails++;
            $display("FAIL %s: irq/err/rdata actual %b/%b/%h expected %b/%b/%h",
                     tag, irq, err, rdata, m_irq, m_err, m_rdata);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input bit t, input string tag);
        step(1, 1, a, d, t, tag);
    endtask

    task automatic rd(input logic [4:0] a, input bit t, input string tag);
        step(1, 0, a, 32'h0, t, tag);
    endtask

    task automatic idle(input int n, input bit t, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 5'h0, 32'h0, t, tag);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        tick = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values, ticks ignored while idle
        idle(3, 1, "R1 idle after reset");
        rd(5'h10, 1, "R1 counter zero");
        rd(5'h14, 1, "R1 status zero");
        rd(5'h1C, 1, "R1 enable zero");

        // R3: illegal accesses
        rd(5'h00, 0, "R3 read of target");
        wr(5'h10, 32'h5, 0, "R3 write of counter");
        wr(5'h04, 32'h1, 0, "R3 unmapped write");
        rd(5'h18, 0, "R3 unmapped read");
        wr(5'h14, 32'h1, 0, "R3 nonzero status write");
        rd(5'h10, 0, "R3 counter unchanged");

        // R2/R4/R7/R5: armed run with enable set
        wr(5'h1C, 32'h1, 0, "R2 enable write");
        rd(5'h1C, 0, "R2 enable read");
        wr(5'h00, 32'h5, 0, "R4 arm target 5");
        idle(3, 0, "R4 no tick no advance");
        rd(5'h10, 0, "R4 counter still zero");
        idle(6, 1, "R7 landing raises irq");
        rd(5'h10, 1, "R5 counter held on target");
        idle(5, 1, "R5 held through ticks");
        rd(5'h10, 1, "R5 counter still target");
        rd(5'h14, 1, "R7 status reads one");

        // R9: clear, then clear again
        wr(5'h14, 32'h0, 1, "R9 clear drops irq");
        wr(5'h14, 32'h0, 1, "R9 clear when clear");
        rd(5'h14, 1, "R9 status zero");

        // R8: enable zero, no flag
        wr(5'h1C, 32'h0, 1, "R8 enable off");
        wr(5'h00, 32'h8, 1, "R8 arm target 8");
        idle(6, 1, "R8 landing without flag");
        rd(5'h14, 1, "R8 status stays zero");
        rd(5'h10, 1, "R8 counter at 8");

        // R6: wrap below, then equal target
        wr(5'h1C, 32'h1, 1, "R6 enable on");
        wr(5'h00, 32'h3, 1, "R6 target below counter");
        idle(1030, 1, "R6 wrap run");
        rd(5'h10, 1, "R6 landed after wrap");
        wr(5'h14, 32'h0, 1, "R6 clear");
        wr(5'h00, 32'h3, 1, "R6 target equals counter");
        idle(1030, 1, "R6 full period run");
        rd(5'h10, 1, "R6 landed after full period");

        // R10: landing beats clear in the same cycle
        wr(5'h00, 32'h5, 0, "R10 arm target 5");
        idle(1, 1, "R10 approach");
        wr(5'h14, 32'h0, 1, "R10 clear on landing cycle");
        rd(5'h14, 0, "R10 status kept");
        wr(5'h14, 32'h0, 0, "R10 clear");
        // R10: target write on landing cycle cancels it
        wr(5'h00, 32'h7, 0, "R10 arm target 7");
        idle(1, 1, "R10 approach");
        wr(5'h00, 32'h9, 1, "R10 retarget on landing cycle");
        idle(4, 1, "R10 run to new target");
        rd(5'h10, 0, "R10 counter at 9");
        wr(5'h14, 32'h0, 0, "R10 clear");

        // R11: retarget mid-run
        wr(5'h00, 32'd40, 1, "R11 arm far target");
        idle(3, 1, "R11 running");
        wr(5'h00, 32'd20, 1, "R11 retarget nearer");
        idle(15, 1, "R11 run to nearer target");
        rd(5'h10, 1, "R11 counter at 20");

        // Random mix
        for (int k = 0; k < 4000; k++) begin
            int unsigned op;
            bit t;
            op = $urandom % 100;
            t  = ($urandom % 10) < 8;
            if (op < 40) idle(1, t, "R4 random tick");
            else if (op < 60) begin
                case ($urandom % 3)
                    0: rd(5'h10, t, "R2 random counter read");
                    1: rd(5'h14, t, "R2 random status read");
                    default: rd(5'h1C, t, "R2 random enable read");
                endcase
            end else if (op < 72) begin
                int unsigned tg;
                if (($urandom % 20) == 0) tg = $urandom;
                else tg = (m_cnt + 1 + ($urandom % 24)) & MASK;
                wr(5'h00, tg, t, "R11 random target write");
            end else if (op < 82) wr(5'h14, 32'h0, t, "R9 random clear");
            else if (op < 88) wr(5'h1C, (($urandom % 3) == 0) ? 32'h0 : $urandom, t, "R8 random enable");
            else if (op < 94) wr(5'h14, ($urandom % 7) + 1, t, "R3 random bad status write");
            else step(1, $urandom % 2, 5'($urandom), $urandom, t, "R3 random offset");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule